// File: doc/BRIEF.md
# Flash ECC Response and Abort Controller

This block sits beside an embedded flash command engine and decides what happens when the read path reports an ECC error. A small configuration register chooses, separately for the flash interrupt and for the bus fault, whether single-bit errors, double-bit errors, both or neither are reported. A bypass bit skips the corrected data and returns one raw 32-bit half of the stored 64-bit word instead. Writes to the configuration register are protected by a magic unlock value, and that value is good for one write attempt only.

The block also holds one abort enable for each of 55 system interrupt lines. While the flash engine is busy with a command, any enabled interrupt that is pending raises an abort request to the engine. If the command is a write, the address being programmed when the abort starts is kept in a read-only register. Software reads that register before it issues the next command.

Top module: `flash_ecc_guard`

## Requirements
- R1: A write to the configuration register (select 1) is applied only if the unlock register (select 0) holds 0x5ECCACCE. Every configuration write clears the unlock register, so a second configuration write without a fresh unlock is discarded.
- R2: A configuration write made while the unlock register holds any other value is discarded. It still clears the unlock register.
- R3: Configuration bits [4:3] select flash interrupt reporting: 00 none, 01 double-bit errors only, 10 single-bit errors only, 11 both.
- R4: Configuration bits [2:1] select bus-fault reporting with the same encoding as R3.
- R5: A read beat that flags both single-bit and double-bit errors is reported as a double-bit error.
- R6: With configuration bit 0 set, `rd_data` is `rd_raw[63:32]` when `rd_upper` is 1 and `rd_raw[31:0]` otherwise, and no interrupt or bus fault is raised. With bit 0 clear, `rd_data` is `rd_fixed`.
- R7: Abort enables for lines 0 to 31 are held in select 2 (bit n is line n). Enables for lines 32 to 54 are held in bits [22:0] of select 3. Bits [31:23] of select 3 read as zero.
- R8: `cmd_abort` is 1 in the cycle after a cycle in which `cmd_busy` is 1 and some pending line is enabled. It is 0 after any cycle in which `cmd_busy` is 0.
- R9: When an abort begins during a write command (`cmd_write` is 1), `cmd_addr` is captured into the abort address register (select 4). The value then holds for as long as the abort continues.
- R10: After reset, selects 1, 2 and 3 read zero and all outputs are zero. Configuration bits [31:5] always read zero. The abort address is undefined after reset.
- R11: `ecc_irq` and `ecc_fault` are pulses one cycle after the reporting read beat, one pulse per beat, and they are zero after a cycle with no beat.
- R12: `reg_rdata` shows the register chosen by `reg_sel` one cycle after `reg_sel` is presented. The unlock register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| rd_beat | input | 1 | A flash read beat is present |
| ecc_sgl | input | 1 | Codec flagged a single-bit error |
| ecc_dbl | input | 1 | Codec flagged a double-bit error |
| rd_raw | input | 64 | Raw stored word |
| rd_upper | input | 1 | Requested address selects the upper half |
| rd_fixed | input | 32 | Corrected data from the codec |
| rd_data | output | 32 | Data returned to the bus |
| ecc_irq | output | 1 | Flash interrupt pulse |
| ecc_fault | output | 1 | Bus fault pulse |
| irq_lines | input | 55 | Pending system interrupts |
| cmd_busy | input | 1 | Flash engine is running a command |
| cmd_write | input | 1 | Running command is a write |
| cmd_addr | input | 32 | Address currently being written |
| cmd_abort | output | 1 | Abort request to the flash engine |

## Verification
Several properties are checked on every cycle: the unlock value is consumed by every configuration write, a write without the unlock leaves the configuration unchanged, bypass and idle beats never raise a report, a double-bit beat is never reported under a single-bit-only setting, an idle engine never receives an abort, and the captured address stays fixed during an abort. The bench shows the rest. It sweeps all sixteen interrupt and fault settings against every error pattern, and it moves one enable across all 55 interrupt lines, checking both the abort and the enable readback. It also covers the raw-half selection in bypass and the reset and reserved readback values.

// File: rtl/fecc_pkg.sv
package fecc_pkg;
  localparam int REG_W   = 32;
  localparam int SEL_W   = 3;
  localparam logic [REG_W-1:0] UNLOCK_VALUE = 32'h5ECC_ACCE;

  localparam logic [SEL_W-1:0] SEL_KEY  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CFG  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ENLO = 3'd2;
  localparam logic [SEL_W-1:0] SEL_ENHI = 3'd3;
  localparam logic [SEL_W-1:0] SEL_ADDR = 3'd4;

  // bit 0 of each select: double-bit errors, bit 1: single-bit errors
  typedef struct packed {
    logic [1:0] irq_sel;
    logic [1:0] fault_sel;
    logic       bypass;
  } ecc_cfg_t;

  localparam int CFG_W = $bits(ecc_cfg_t);
endpackage

// File: rtl/fecc_cfg_regs.sv
module fecc_cfg_regs
  import fecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output ecc_cfg_t         cfg
);
  logic [REG_W-1:0] key_q;
  ecc_cfg_t         cfg_q;
  logic             wr_key, wr_cfg, unlocked;

  assign wr_key   = reg_wr && (reg_sel == SEL_KEY);
  assign wr_cfg   = reg_wr && (reg_sel == SEL_CFG);
  assign unlocked = (key_q == UNLOCK_VALUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
      cfg_q <= '0;
    end else begin
      if (wr_cfg) begin
        key_q <= '0;
        if (unlocked) cfg_q <= ecc_cfg_t'(reg_wdata[CFG_W-1:0]);
      end else if (wr_key) begin
        key_q <= reg_wdata;
      end
    end
  end

  assign cfg = cfg_q;

  // R1: the unlock value never survives a configuration write
  a_r1_key_single_use: assert property (@(posedge clk) disable iff (rst)
    wr_cfg |=> (key_q == '0));

  // R2: a configuration write without the unlock changes nothing
  a_r2_locked_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && !unlocked) |=> $stable(cfg_q));
endmodule

// File: rtl/fecc_report.sv
module fecc_report
  import fecc_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  ecc_cfg_t            cfg,
  input  logic                rd_beat,
  input  logic                ecc_sgl,
  input  logic                ecc_dbl,
  input  logic [WORD_W-1:0]   rd_raw,
  input  logic                rd_upper,
  input  logic [WORD_W/2-1:0] rd_fixed,
  output logic [WORD_W/2-1:0] rd_data,
  output logic                ecc_irq,
  output logic                ecc_fault
);
  localparam int HALF_W = WORD_W / 2;

  logic              live, is_dbl, is_sgl, irq_d, fault_d;
  logic [HALF_W-1:0] raw_half, data_d;

  always_comb begin
    live     = rd_beat && !cfg.bypass;
    is_dbl   = ecc_dbl;
    is_sgl   = ecc_sgl && !ecc_dbl;
    irq_d    = live && ((is_dbl && cfg.irq_sel[0])   || (is_sgl && cfg.irq_sel[1]));
    fault_d  = live && ((is_dbl && cfg.fault_sel[0]) || (is_sgl && cfg.fault_sel[1]));
    raw_half = rd_upper ? rd_raw[WORD_W-1:HALF_W] : rd_raw[HALF_W-1:0];
    data_d   = rd_data;
    if (rd_beat) data_d = cfg.bypass ? raw_half : rd_fixed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ecc_irq   <= 1'b0;
      ecc_fault <= 1'b0;
      rd_data   <= '0;
    end else begin
      ecc_irq   <= irq_d;
      ecc_fault <= fault_d;
      rd_data   <= data_d;
    end
  end

  // R6: bypass mode never reports
  a_r6_bypass_silent: assert property (@(posedge clk) disable iff (rst)
    (rd_beat && cfg.bypass) |=> !(ecc_irq || ecc_fault));

  // R11: no beat, no report
  a_r11_no_beat_no_pulse: assert property (@(posedge clk) disable iff (rst)
    !rd_beat |=> !(ecc_irq || ecc_fault));

  // R5: a beat with a double-bit flag is never reported as single-bit
  a_r5_double_wins: assert property (@(posedge clk) disable iff (rst)
    (rd_beat && ecc_dbl && cfg.irq_sel == 2'b10) |=> !ecc_irq);
endmodule

// File: rtl/fecc_abort.sv
module fecc_abort
  import fecc_pkg::*;
#(
  parameter int NUM_IRQ = 55,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [SEL_W-1:0]   reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               cmd_busy,
  input  logic               cmd_write,
  input  logic [ADDR_W-1:0]  cmd_addr,
  output logic [NUM_IRQ-1:0] abort_en,
  output logic [ADDR_W-1:0]  abort_addr,
  output logic               cmd_abort
);
  localparam int LO_W = REG_W;
  localparam int HI_W = NUM_IRQ - LO_W;

  logic [NUM_IRQ-1:0] en_q;
  logic               hit, start;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_ENLO) en_q[LO_W-1:0]       <= reg_wdata;
      if (reg_sel == SEL_ENHI) en_q[NUM_IRQ-1:LO_W] <= reg_wdata[HI_W-1:0];
    end
  end

  assign hit   = cmd_busy && |(irq_lines & en_q);
  assign start = hit && !cmd_abort;

  always_ff @(posedge clk) begin
    if (rst) cmd_abort <= 1'b0;
    else     cmd_abort <= hit;
  end

  // capture register has no reset: contents undefined until first abort
  always_ff @(posedge clk) begin
    if (start && cmd_write) abort_addr <= cmd_addr;
  end

  assign abort_en = en_q;

  // R8: an idle engine is never asked to abort
  a_r8_idle_no_abort: assert property (@(posedge clk) disable iff (rst)
    !cmd_busy |=> !cmd_abort);

  // R9: the captured address is frozen while the abort persists
  a_r9_addr_held: assert property (@(posedge clk) disable iff (rst)
    (cmd_abort && hit) |=> $stable(abort_addr));
endmodule

// File: rtl/flash_ecc_guard.sv
module flash_ecc_guard
  import fecc_pkg::*;
#(
  parameter int NUM_IRQ = 55,
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [SEL_W-1:0]    reg_sel,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                rd_beat,
  input  logic                ecc_sgl,
  input  logic                ecc_dbl,
  input  logic [WORD_W-1:0]   rd_raw,
  input  logic                rd_upper,
  input  logic [WORD_W/2-1:0] rd_fixed,
  output logic [WORD_W/2-1:0] rd_data,
  output logic                ecc_irq,
  output logic                ecc_fault,
  input  logic [NUM_IRQ-1:0]  irq_lines,
  input  logic                cmd_busy,
  input  logic                cmd_write,
  input  logic [ADDR_W-1:0]   cmd_addr,
  output logic                cmd_abort
);
  localparam int HI_W = NUM_IRQ - REG_W;

  ecc_cfg_t           cfg;
  logic [NUM_IRQ-1:0] abort_en;
  logic [ADDR_W-1:0]  abort_addr;
  logic [REG_W-1:0]   rdata_d;

  fecc_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cfg(cfg)
  );

  fecc_report #(.WORD_W(WORD_W)) u_report (
    .clk(clk), .rst(rst), .cfg(cfg), .rd_beat(rd_beat),
    .ecc_sgl(ecc_sgl), .ecc_dbl(ecc_dbl), .rd_raw(rd_raw),
    .rd_upper(rd_upper), .rd_fixed(rd_fixed), .rd_data(rd_data),
    .ecc_irq(ecc_irq), .ecc_fault(ecc_fault)
  );

  fecc_abort #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_abort (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .irq_lines(irq_lines), .cmd_busy(cmd_busy),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .abort_en(abort_en),
    .abort_addr(abort_addr), .cmd_abort(cmd_abort)
  );

  always_comb begin
    rdata_d = '0;
    case (reg_sel)
      SEL_CFG:  rdata_d[CFG_W-1:0]  = cfg;
      SEL_ENLO: rdata_d             = abort_en[REG_W-1:0];
      SEL_ENHI: rdata_d[HI_W-1:0]   = abort_en[NUM_IRQ-1:REG_W];
      SEL_ADDR: rdata_d[ADDR_W-1:0] = abort_addr;
      default:  rdata_d             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rdata_d;
  end

  // R10, R7: reserved bits of the configuration and high enable registers stay zero
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_sel == SEL_CFG) |=> (reg_rdata[REG_W-1:CFG_W] == '0));
  a_r7_hi_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_sel == SEL_ENHI) |=> (reg_rdata[REG_W-1:HI_W] == '0));
endmodule

// File: tb/test_flash_ecc_guard.sv
module test_flash_ecc_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 55;
  localparam logic [31:0] KEY = 32'h5ECC_ACCE;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 0;
  logic [2:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        rd_beat = 0, ecc_sgl = 0, ecc_dbl = 0, rd_upper = 0;
  logic [63:0] rd_raw = 0;
  logic [31:0] rd_fixed = 0, rd_data;
  logic        ecc_irq, ecc_fault;
  logic [NIRQ-1:0] irq_lines = 0;
  logic        cmd_busy = 0, cmd_write = 0, cmd_abort;
  logic [31:0] cmd_addr = 0;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_ecc_guard i_flash_ecc_guard (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_beat(rd_beat),
    .ecc_sgl(ecc_sgl), .ecc_dbl(ecc_dbl), .rd_raw(rd_raw),
    .rd_upper(rd_upper), .rd_fixed(rd_fixed), .rd_data(rd_data),
    .ecc_irq(ecc_irq), .ecc_fault(ecc_fault), .irq_lines(irq_lines),
    .cmd_busy(cmd_busy), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_abort(cmd_abort)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic set_cfg(logic [4:0] v);
    wr(3'd0, KEY); wr(3'd1, {27'd0, v});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state
    check("R10 irq", ecc_irq, 0); check("R10 fault", ecc_fault, 0);
    check("R10 abort", cmd_abort, 0);
    rd(3'd1, v); check("R10 cfg", v, 0);
    rd(3'd2, v); check("R10 enlo", v, 0);
    rd(3'd3, v); check("R10 enhi", v, 0);

    // R1 / R12: unlocked write applies, key reads zero, key single use
    wr(3'd0, KEY); rd(3'd0, v); check("R12 key reads zero", v, 0);
    wr(3'd1, 32'h1E); rd(3'd1, v); check("R1 cfg applied", v, 32'h1E);
    wr(3'd1, 32'h00); rd(3'd1, v); check("R1 second write dropped", v, 32'h1E);
    // R2: wrong key discarded and cleared
    wr(3'd0, 32'h1234); wr(3'd1, 32'h1F); rd(3'd1, v); check("R2 wrong key", v, 32'h1E);
    wr(3'd0, KEY ^ 32'h1); wr(3'd1, 32'h06); wr(3'd1, 32'h04);
    rd(3'd1, v); check("R2 near key", v, 32'h1E);
    // R10: reserved bits
    set_cfg(5'd0); wr(3'd0, KEY); wr(3'd1, 32'hFFFF_FFE0); rd(3'd1, v);
    check("R10 reserved zero", v, 0);

    // R3 R4 R5 R11: full sweep of settings and error patterns
    for (int is = 0; is < 4; is++) begin
      for (int fs = 0; fs < 4; fs++) begin
        set_cfg({is[1:0], fs[1:0], 1'b0});
        for (int e = 0; e < 4; e++) begin
          logic eirq, eflt;
          logic [31:0] fx;
          fx = 32'hA000_0000 + is*64 + fs*8 + e;
          eirq = (e[1]) ? is[0] : (e[0] ? is[1] : 1'b0);
          eflt = (e[1]) ? fs[0] : (e[0] ? fs[1] : 1'b0);
          @(negedge clk); rd_beat = 1; ecc_sgl = e[0]; ecc_dbl = e[1];
          rd_fixed = fx; rd_raw = 64'hDEAD_BEEF_0BAD_F00D;
          @(negedge clk); rd_beat = 0; ecc_sgl = 0; ecc_dbl = 0;
          check("R3 irq select", ecc_irq, eirq);
          check("R4 fault select", ecc_fault, eflt);
          if (e == 3) check("R5 both as double", {ecc_irq, ecc_fault}, {is[0], fs[0]});
          check("R6 corrected data", rd_data, fx);
          @(negedge clk);
          check("R11 single pulse", {ecc_irq, ecc_fault}, 0);
        end
      end
    end

    // R6: bypass returns raw halves, no reports
    set_cfg(5'b11111);
    for (int u = 0; u < 2; u++) begin
      @(negedge clk); rd_beat = 1; ecc_sgl = 1; ecc_dbl = 1; rd_upper = u[0];
      rd_raw = 64'h1111_2222_3333_4444; rd_fixed = 32'h5555_6666;
      @(negedge clk); rd_beat = 0; ecc_sgl = 0; ecc_dbl = 0;
      check("R6 raw half", rd_data, u ? 32'h1111_2222 : 32'h3333_4444);
      check("R6 bypass silent", {ecc_irq, ecc_fault}, 0);
    end

    // R7 R8 R9: one enable swept across every line
    for (int i = 0; i < NIRQ; i++) begin
      logic [NIRQ-1:0] m;
      m = '0; m[i] = 1'b1;
      wr(3'd2, m[31:0]); wr(3'd3, {9'd0, m[NIRQ-1:32]});
      rd(3'd2, v); check("R7 enlo", v, m[31:0]);
      rd(3'd3, v); check("R7 enhi", v, {9'd0, m[NIRQ-1:32]});
      @(negedge clk); irq_lines = ~m; cmd_busy = 1; cmd_write = 1;
      @(negedge clk); check("R8 other lines ignored", cmd_abort, 0);
      irq_lines = m; cmd_addr = 32'h100 + i*4;
      @(negedge clk); check("R8 abort raised", cmd_abort, 1);
      cmd_addr = 32'hFFFF_0000;
      @(negedge clk); check("R8 abort held", cmd_abort, 1);
      cmd_busy = 0;
      @(negedge clk); check("R8 idle drops abort", cmd_abort, 0);
      irq_lines = 0; cmd_write = 0;
      rd(3'd4, v); check("R9 captured address", v, 32'h100 + i*4);
    end

    // R7: reserved bits of high enables
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); check("R7 hi reserved", v, 32'h007F_FFFF);
    // R8: idle engine with every line enabled and pending
    wr(3'd2, 32'hFFFF_FFFF);
    @(negedge clk); irq_lines = '1; cmd_busy = 0;
    @(negedge clk); check("R8 idle ignored", cmd_abort, 0);
    // R9: non-write command keeps the old address
    cmd_busy = 1; cmd_write = 0; cmd_addr = 32'h7777;
    @(negedge clk); check("R8 erase abort", cmd_abort, 1);
    cmd_busy = 0; irq_lines = 0;
    rd(3'd4, v); check("R9 non-write no capture", v, 32'h100 + (NIRQ-1)*4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule